// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block is a sequential integer multiplier that works through the multiplier operand one bit per clock and adds the shifted multiplicand into a double-width accumulator for every set bit. It handles three operand sizes: a quarter, a half and the whole of the `XLEN`-bit datapath (8, 16 and 32 bits by default). Each size can run in unsigned or two's-complement signed mode. In signed mode both operands are first turned into magnitudes. Iteration then runs on those magnitudes, and the product is negated on the way out when the operand signs differ.

The loop ends once every multiplier bit not yet consumed is zero. A small multiplier therefore retires in a few cycles, while a multiplier with its top bit set takes the full width. Requests enter through a valid/ready pair, and `in_ready` is simply the inverse of `busy`. While an operation is running the upstream is held off, and a valid presented during that time is not taken. The result side has no back-pressure. `done` pulses for one cycle, and the product halves hold their value until the next request is accepted.

Top module: `iter_mul`

## Requirements
- R1: A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `busy` is low, and `busy` is high in the cycle after an acceptance.
- R2: In unsigned mode (`op_signed`=0) the result is the unsigned product of the two operand fields, 2W bits wide. The low W bits appear on `prod_lo[W-1:0]` and the high W bits on `prod_hi[W-1:0]`.
- R3: In signed mode (`op_signed`=1) the operand fields are taken as two's complement W-bit values, and the 2W-bit two's complement product is split the same way as in R2. This includes the most negative value of either operand.
- R4: `op_size` sets W: 0 gives XLEN/4, 1 gives XLEN/2, 2 and 3 give XLEN. Operand bits at W and above are ignored, and the output bits at W and above of `prod_lo` and `prod_hi` are zero.
- R5: `busy` stays high for exactly max(1, k+1) cycles after acceptance, where k is the index of the highest set bit of the multiplier magnitude. `done` is high in the cycle right after the last busy cycle.
- R6: A zero multiplier field completes after one busy cycle with a product of zero.
- R7: `in_valid` raised while `busy` is high is ignored: the operation in flight keeps its operands, its result and its cycle count.
- R8: `done` lasts one cycle. `prod_lo` and `prod_hi` keep their value from completion until the next accepted request.
- R9: After reset, `busy` and `done` are low, `in_ready` is high and both product halves are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request can be taken |
| op_size | input | 2 | Operand size select (see R4) |
| op_signed | input | 1 | 1 = two's complement operands |
| multiplicand | input | XLEN | Multiplicand, low W bits used |
| multiplier | input | XLEN | Multiplier, low W bits used |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_lo | output | XLEN | Low half of the product |
| prod_hi | output | XLEN | High half of the product |

## Verification
The properties assume that `op_size` and `multiplier` are meaningful only in a cycle where a request is accepted. Outside such a cycle, what those inputs carry is free. The properties also assume that `in_valid` may be dropped at any time without harm, since the block keeps no promise about a request it did not take. The stimulus changes inputs only at falling edges and holds each request for a single cycle. It waits for `in_ready` before presenting a new request, except for the deliberate pulses sent during a busy period to exercise R7.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;
  typedef enum logic [1:0] {
    SZ_QUARTER = 2'd0,
    SZ_HALF    = 2'd1,
    SZ_FULL    = 2'd2,
    SZ_FULL_X  = 2'd3
  } opsize_e;
endpackage

// File: rtl/iter_mul_prep.sv
module iter_mul_prep
  import iter_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  opsize_e           size,
  input  logic              sgn,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  output logic [XLEN-1:0]   amag,
  output logic [XLEN-1:0]   bmag,
  output logic              neg
);
  localparam int QW = XLEN / 4;
  localparam int HW = XLEN / 2;

  logic [XLEN-1:0]       mask;
  logic [1:0][XLEN-1:0]  raw;
  logic [1:0][XLEN-1:0]  fld;
  logic [1:0][XLEN-1:0]  mag;
  logic [1:0]            sbit;

  always_comb begin
    case (size)
      SZ_QUARTER: mask = {{(XLEN-QW){1'b0}}, {QW{1'b1}}};
      SZ_HALF:    mask = {{(XLEN-HW){1'b0}}, {HW{1'b1}}};
      default:    mask = {XLEN{1'b1}};
    endcase
  end

  assign raw[0] = opa;
  assign raw[1] = opb;

  for (genvar g = 0; g < 2; g++) begin : g_opd
    assign fld[g]  = raw[g] & mask;
    assign sbit[g] = sgn & ((size == SZ_QUARTER) ? fld[g][QW-1] :
                            (size == SZ_HALF)    ? fld[g][HW-1] :
                                                   fld[g][XLEN-1]);
    assign mag[g]  = sbit[g] ? ((~fld[g] + 1'b1) & mask) : fld[g];
  end

  assign amag = mag[0];
  assign bmag = mag[1];
  assign neg  = sbit[0] ^ sbit[1];
endmodule

// File: rtl/iter_mul_core.sv
module iter_mul_core
  import iter_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XLEN-1:0]   amag,
  input  logic [XLEN-1:0]   bmag,
  input  logic              neg_in,
  input  opsize_e           size_in,
  output logic              busy,
  output logic              done,
  output logic [2*XLEN-1:0] acc,
  output logic              neg_q,
  output opsize_e           size_q
);
  localparam int AW = 2 * XLEN;

  logic [AW-1:0]   mcand;
  logic [XLEN-1:0] mplier;
  logic            last;

  // no unconsumed set bit above the one being retired now
  assign last = (mplier[XLEN-1:1] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      neg_q  <= 1'b0;
      size_q <= SZ_QUARTER;
    end else begin
      done <= 1'b0;
      if (load) begin
        acc    <= '0;
        mcand  <= {{XLEN{1'b0}}, amag};
        mplier <= bmag;
        neg_q  <= neg_in;
        size_q <= size_in;
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iter_mul_fix.sv
module iter_mul_fix
  import iter_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2*XLEN-1:0] acc,
  input  logic              neg,
  input  opsize_e           size,
  output logic [XLEN-1:0]   lo,
  output logic [XLEN-1:0]   hi
);
  localparam int QW = XLEN / 4;
  localparam int HW = XLEN / 2;

  logic [2*XLEN-1:0] full;

  assign full = neg ? (~acc + 1'b1) : acc;

  always_comb begin
    case (size)
      SZ_QUARTER: begin
        lo = {{(XLEN-QW){1'b0}}, full[QW-1:0]};
        hi = {{(XLEN-QW){1'b0}}, full[2*QW-1:QW]};
      end
      SZ_HALF: begin
        lo = {{(XLEN-HW){1'b0}}, full[HW-1:0]};
        hi = {{(XLEN-HW){1'b0}}, full[2*HW-1:HW]};
      end
      default: begin
        lo = full[XLEN-1:0];
        hi = full[2*XLEN-1:XLEN];
      end
    endcase
  end
endmodule

// File: rtl/iter_mul.sv
module iter_mul
  import iter_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      op_size,
  input  logic            op_signed,
  input  logic [XLEN-1:0] multiplicand,
  input  logic [XLEN-1:0] multiplier,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] prod_lo,
  output logic [XLEN-1:0] prod_hi
);
  localparam int AW = 2 * XLEN;

  opsize_e         size_in, size_q;
  logic [XLEN-1:0] amag, bmag;
  logic            neg_in, neg_q, load;
  logic [AW-1:0]   acc;

  assign size_in  = opsize_e'(op_size);
  assign in_ready = ~busy;
  assign load     = in_valid & in_ready;

  iter_mul_prep #(.XLEN(XLEN)) u_prep (
    .size (size_in),
    .sgn  (op_signed),
    .opa  (multiplicand),
    .opb  (multiplier),
    .amag (amag),
    .bmag (bmag),
    .neg  (neg_in)
  );

  iter_mul_core #(.XLEN(XLEN)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .amag    (amag),
    .bmag    (bmag),
    .neg_in  (neg_in),
    .size_in (size_in),
    .busy    (busy),
    .done    (done),
    .acc     (acc),
    .neg_q   (neg_q),
    .size_q  (size_q)
  );

  iter_mul_fix #(.XLEN(XLEN)) u_fix (
    .acc  (acc),
    .neg  (neg_q),
    .size (size_q),
    .lo   (prod_lo),
    .hi   (prod_hi)
  );
endmodule

// File: rtl/iter_mul_chk.sv
module iter_mul_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      op_size,
  input logic [XLEN-1:0] multiplier,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] prod_lo,
  input logic [XLEN-1:0] prod_hi
);
  logic b_zero;

  always_comb begin
    case (op_size)
      2'd0:    b_zero = (multiplier[XLEN/4-1:0] == '0);
      2'd1:    b_zero = (multiplier[XLEN/2-1:0] == '0);
      default: b_zero = (multiplier == '0);
    endcase
  end

  // R1
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R5
  fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  zero_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && b_zero) |=> busy ##1 (done && prod_lo == '0 && prod_hi == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=> ($stable(prod_lo) && $stable(prod_hi)));
endmodule

bind iter_mul iter_mul_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .op_size    (op_size),
  .multiplier (multiplier),
  .busy       (busy),
  .done       (done),
  .prod_lo    (prod_lo),
  .prod_hi    (prod_hi)
);

// File: tb/iter_mul_bench.sv
module iter_mul_bench;
  localparam int XLEN = 32;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [XLEN-1:0] lo;
    logic [XLEN-1:0] hi;
    int              n;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      op_size = 2'd0;
  logic            op_signed = 1'b0;
  logic [XLEN-1:0] multiplicand = '0;
  logic [XLEN-1:0] multiplier = '0;
  logic            in_ready, busy, done;
  logic [XLEN-1:0] prod_lo, prod_hi;

  int   errors = 0;
  int   checks = 0;
  int   cnt = 0;
  exp_t sb[$];
  exp_t last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_mul #(.XLEN(XLEN)) u_iter_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_size(op_size), .op_signed(op_signed), .multiplicand(multiplicand),
    .multiplier(multiplier), .busy(busy), .done(done),
    .prod_lo(prod_lo), .prod_hi(prod_hi)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic exp_t ref_model(input logic [1:0] sz, input logic sg,
                                     input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                     input string tag);
    exp_t e;
    int w;
    logic [63:0] mask, af, bf, av, bv, p, bm;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask = (64'h1 << w) - 64'h1;
    af   = {32'h0, a} & mask;
    bf   = {32'h0, b} & mask;
    av   = (sg && af[w-1]) ? (af | ~mask) : af;
    bv   = (sg && bf[w-1]) ? (bf | ~mask) : bf;
    p    = av * bv;
    e.lo = XLEN'(p & mask);
    e.hi = XLEN'((p >> w) & mask);
    bm   = (sg && bf[w-1]) ? ((~bf + 64'h1) & mask) : bf;
    e.n  = 1;
    for (int i = 0; i < w; i++) if (bm[i]) e.n = i + 1;
    e.tag = tag;
    return e;
  endfunction

  // driver: waits for ready, presents one request, pushes its expectation
  task automatic send(input logic [1:0] sz, input logic sg,
                      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                      input string tag);
    while (!in_ready) @(negedge clk);
    op_size = sz; op_signed = sg; multiplicand = a; multiplier = b;
    in_valid = 1'b1;
    sb.push_back(ref_model(sz, sg, a, b, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: counts busy cycles and compares each completion with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy) cnt++;
        if (done) begin
          if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected completion", 64'(prod_lo), 64'h0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            last_exp = e;
            check(prod_lo == e.lo && prod_hi == e.hi, e.tag,
                  {prod_hi, prod_lo}, {e.hi, e.lo});
            check(cnt == e.n, "R5 cycle count", 64'(cnt), 64'(e.n));
          end
          cnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done, "R9 busy/done after reset", {62'h0, busy, done}, 64'h0);
    check(in_ready, "R9 in_ready after reset", 64'(in_ready), 64'h1);
    check(prod_lo == '0 && prod_hi == '0, "R9 product after reset",
          {prod_hi, prod_lo}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 unsigned, each size
    send(2'd0, 1'b0, 32'h0000_00FF, 32'h0000_00FF, "R2 u8 all ones");
    send(2'd1, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, "R2 u16 all ones");
    send(2'd2, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 u32 all ones");
    send(2'd2, 1'b0, 32'h1234_5678, 32'h0000_0005, "R2 u32 short multiplier");
    // R3 signed including most negative
    send(2'd0, 1'b1, 32'h0000_0080, 32'h0000_0080, "R3 s8 min*min");
    send(2'd1, 1'b1, 32'h0000_8000, 32'h0000_0003, "R3 s16 min*3");
    send(2'd2, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R3 s32 min*-1");
    send(2'd2, 1'b1, 32'h0000_0007, 32'hFFFF_FFF9, "R3 s32 7*-7");
    send(2'd0, 1'b1, 32'h0000_00FF, 32'h0000_007F, "R3 s8 -1*127");
    // R4 upper operand bits ignored, size code 3 acts as full
    send(2'd0, 1'b0, 32'hABCD_EF12, 32'h5A5A_5A03, "R4 u8 upper bits ignored");
    send(2'd1, 1'b1, 32'hFFFF_0001, 32'h1234_FFFE, "R4 s16 upper bits ignored");
    send(2'd3, 1'b0, 32'h0001_0000, 32'h0001_0000, "R4 size code 3 full width");
    // R6 zero multiplier
    send(2'd2, 1'b1, 32'hDEAD_BEEF, 32'h0000_0000, "R6 zero multiplier");
    send(2'd0, 1'b0, 32'h0000_0011, 32'hFFFF_FF00, "R6 zero field upper set");
    drain();

    // R7 request during busy is ignored
    send(2'd2, 1'b0, 32'h0000_0003, 32'h8000_0001, "R7 busy request ignored");
    @(negedge clk);
    check(!in_ready, "R1 in_ready low while busy", 64'(in_ready), 64'h0);
    op_size = 2'd0; op_signed = 1'b1; multiplicand = 32'h55; multiplier = 32'h0;
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R8 hold after completion
    repeat (4) @(negedge clk);
    check(prod_lo == last_exp.lo && prod_hi == last_exp.hi, "R8 product held",
          {prod_hi, prod_lo}, {last_exp.hi, last_exp.lo});
    check(!done, "R8 done single cycle", 64'(done), 64'h0);

    // random mix R2 R3 R4 R5
    for (int k = 0; k < 60; k++) begin
      logic [1:0] sz;
      logic sg;
      logic [XLEN-1:0] a, b;
      sz = 2'($urandom_range(0, 3));
      sg = 1'($urandom_range(0, 1));
      a  = $urandom();
      b  = $urandom() >> $urandom_range(0, 31);
      send(sz, sg, a, b, sg ? "R3 random signed" : "R2 random unsigned");
    end
    drain();
    check(sb.size() == 0, "R1 all requests completed", 64'(sb.size()), 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule